// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Port-Change Detect

This block collects interrupt events for a small microcontroller-style core and decides when the core must leave its current flow for the interrupt routine. It has three core sources and a parameterized group of peripheral request lines. The core sources are a timer overflow pulse, an external pin with a selectable active edge, and a change detector on a 4-bit input port. Each event sets a sticky flag. A flag raises a request only when its own mask is set and the global enable is on. Peripheral flags must also pass a group enable.

When a request is live, the controller takes it on the next clock edge. It pulses a vector request towards the core together with the fixed vector address 0004h and the code of the winning source, and it drops the global enable in the same edge. The core pulses a return strobe at the end of the routine, and the global enable comes back. Software owns the flags and the enables through a small write port with three register selects. A strobe from the core re-latches the port comparison value each time the port is read or written.

Top module: `irq_ctrl`

## Requirements
- R1: Every flag latches on its event whatever the state of its own mask, the peripheral group enable or the global enable.
- R2: A request is raised only when the global enable, a flag and that flag's mask are all set; a peripheral flag (select 2'd1 holds flags, select 2'd2 holds masks, bit k is line k) also needs the group enable (control bit 1).
- R3: Taking a request gives a one-cycle vec_req_o pulse with vec_addr_o = 13'h0004 on the clock edge after the request appears, and clears the global enable (control bit 0) on that same edge.
- R4: Reset clears every register and the global enable; a pulse on iret_i sets the global enable again on the next edge.
- R5: The change flag (control bit 7) sets on every cycle in which the synchronized 4-bit port differs from the stored reference, so a software clear does not hold while the mismatch persists.
- R6: A pulse on port_access_i copies the synchronized port into the reference, ending the mismatch so that a later software clear holds.
- R7: The external flag (control bit 6) sets on a rising pin edge when ext_rise_sel_i is 1 and on a falling edge when it is 0; the other edge has no effect.
- R8: A write through select 2'd0 or 2'd1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged; software cannot set a flag, and taking a request does not clear one.
- R9: When a hardware set and a software clear hit the same flag in one cycle, the flag ends up set.
- R10: vec_src_o reports the winning source with the lowest code taking priority: external pin 0, timer 1, port change 2, peripheral line k as 3+k.
- R11: The external pin and port inputs pass through two synchronizing flops, so a pin edge shows in its flag after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel_i | input | 1 | 1 selects the rising pin edge, 0 the falling edge |
| port_hi_i | input | 4 | Monitored port bits, asynchronous |
| port_access_i | input | 1 | Port read or write strobe; reloads the change reference |
| periph_req_i | input | 8 | Peripheral event pulses, one per line |
| iret_i | input | 1 | Return-from-interrupt strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 control, 1 peripheral flags, 2 peripheral masks, 3 none |
| reg_wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control image: 0 global en, 1 group en, 2..4 timer/ext/change masks, 5..7 timer/ext/change flags |
| pflag_o | output | 8 | Peripheral flags |
| pmask_o | output | 8 | Peripheral masks |
| vec_req_o | output | 1 | One-cycle vector request to the core |
| vec_addr_o | output | 13 | Vector address |
| vec_src_o | output | 4 | Code of the source taken |

## Verification
The properties assume that iret_i only arrives while the global enable is clear, as it would at the end of a routine, and that the event inputs are single-cycle pulses driven away from the clock edge. The bench drives every input at the falling edge and pulses the return strobe only after a take has cleared the enable. The synchronizers come out of reset at zero, so the bench holds the pin and the port low through reset. If it did not, a high input would read as a rising edge or a mismatch in the first cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PFLAG = 2'd1,
    SEL_PMASK = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_GIE   = 0;
  localparam int unsigned CTL_GRP   = 1;
  localparam int unsigned CTL_MASK0 = 2;  // timer, ext, change masks at 2..4
  localparam int unsigned CTL_FLAG0 = 5;  // timer, ext, change flags at 5..7
  localparam int unsigned N_CORE    = 3;

  localparam int unsigned SRC_EXT   = 0;
  localparam int unsigned SRC_TMR   = 1;
  localparam int unsigned SRC_CHG   = 2;
  localparam int unsigned SRC_PER0  = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              rise_sel_i,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic              port_access_i,
  output logic              ext_evt_o,
  output logic              chg_evt_o
);
  logic              pin_prev_q;
  logic [PORT_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_prev_q <= 1'b0;
      ref_q      <= '0;
    end else begin
      pin_prev_q <= pin_s_i;
      if (port_access_i) ref_q <= port_s_i;
    end
  end

  assign ext_evt_o = rise_sel_i ? (pin_s_i & ~pin_prev_q) : (~pin_s_i & pin_prev_q);
  // level-sensitive: re-fires every cycle while port and reference differ
  assign chg_evt_o = |(port_s_i ^ ref_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (wr_i ? (flag_q & keep_i) : flag_q) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned SRC_W    = 4
) (
  input  logic [N_CORE-1:0]   core_flag_i,
  input  logic [N_CORE-1:0]   core_mask_i,
  input  logic [N_PERIPH-1:0] per_flag_i,
  input  logic [N_PERIPH-1:0] per_mask_i,
  input  logic                grp_en_i,
  output logic                pend_o,
  output logic [SRC_W-1:0]    src_o
);
  logic [N_CORE-1:0]   core_live;
  logic [N_PERIPH-1:0] per_live;

  assign core_live = core_flag_i & core_mask_i;
  assign per_live  = per_flag_i & per_mask_i & {N_PERIPH{grp_en_i}};

  // scan lowest priority first so later hits override
  always_comb begin
    pend_o = 1'b0;
    src_o  = '0;
    for (int k = N_PERIPH - 1; k >= 0; k--) begin
      if (per_live[k]) begin
        pend_o = 1'b1;
        src_o  = SRC_W'(SRC_PER0 + k);
      end
    end
    if (core_live[2]) begin pend_o = 1'b1; src_o = SRC_W'(SRC_CHG); end
    if (core_live[0]) begin pend_o = 1'b1; src_o = SRC_W'(SRC_TMR); end
    if (core_live[1]) begin pend_o = 1'b1; src_o = SRC_W'(SRC_EXT); end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned PORT_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 13'h0004,
  localparam int unsigned SRC_W   = $clog2(SRC_PER0 + N_PERIPH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tmr_ovf_i,
  input  logic                ext_pin_i,
  input  logic                ext_rise_sel_i,
  input  logic [PORT_W-1:0]   port_hi_i,
  input  logic                port_access_i,
  input  logic [N_PERIPH-1:0] periph_req_i,
  input  logic                iret_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [N_PERIPH-1:0] pflag_o,
  output logic [N_PERIPH-1:0] pmask_o,
  output logic                vec_req_o,
  output logic [ADDR_W-1:0]   vec_addr_o,
  output logic [SRC_W-1:0]    vec_src_o
);
  reg_sel_e sel;
  logic wr_ctl, wr_pflag, wr_pmask;
  assign sel      = reg_sel_e'(reg_sel_i);
  assign wr_ctl   = reg_wr_i && (sel == SEL_CTRL);
  assign wr_pflag = reg_wr_i && (sel == SEL_PFLAG);
  assign wr_pmask = reg_wr_i && (sel == SEL_PMASK);

  logic              pin_s;
  logic [PORT_W-1:0] port_s;

  irq_sync #(.W(1)) i_sync_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_pin_i), .q_o(pin_s)
  );
  irq_sync #(.W(PORT_W)) i_sync_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(port_hi_i), .q_o(port_s)
  );

  logic ext_evt, chg_evt;
  irq_evt_detect #(.PORT_W(PORT_W)) i_detect (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pin_s_i(pin_s), .rise_sel_i(ext_rise_sel_i),
    .port_s_i(port_s), .port_access_i(port_access_i),
    .ext_evt_o(ext_evt), .chg_evt_o(chg_evt)
  );

  // core flag order: [0] timer, [1] ext, [2] change
  logic [N_CORE-1:0] core_flag;
  irq_flag_bank #(.W(N_CORE)) i_core_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i({chg_evt, ext_evt, tmr_ovf_i}),
    .wr_i(wr_ctl),
    .keep_i(reg_wdata_i[CTL_FLAG0 +: N_CORE]),
    .flag_o(core_flag)
  );

  logic [N_PERIPH-1:0] per_flag;
  irq_flag_bank #(.W(N_PERIPH)) i_per_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(periph_req_i),
    .wr_i(wr_pflag),
    .keep_i(reg_wdata_i[N_PERIPH-1:0]),
    .flag_o(per_flag)
  );

  logic                gie_q, grp_q;
  logic [N_CORE-1:0]   core_mask_q;
  logic [N_PERIPH-1:0] per_mask_q;
  logic                pend, take;
  logic [SRC_W-1:0]    src;

  irq_arbiter #(.N_PERIPH(N_PERIPH), .SRC_W(SRC_W)) i_arb (
    .core_flag_i(core_flag), .core_mask_i(core_mask_q),
    .per_flag_i(per_flag), .per_mask_i(per_mask_q),
    .grp_en_i(grp_q), .pend_o(pend), .src_o(src)
  );

  assign take = gie_q & pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q       <= 1'b0;
      grp_q       <= 1'b0;
      core_mask_q <= '0;
      per_mask_q  <= '0;
    end else begin
      if (take)        gie_q <= 1'b0;
      else if (iret_i) gie_q <= 1'b1;
      else if (wr_ctl) gie_q <= reg_wdata_i[CTL_GIE];
      if (wr_ctl) begin
        grp_q       <= reg_wdata_i[CTL_GRP];
        core_mask_q <= reg_wdata_i[CTL_MASK0 +: N_CORE];
      end
      if (wr_pmask) per_mask_q <= reg_wdata_i[N_PERIPH-1:0];
    end
  end

  logic             vreq_q;
  logic [SRC_W-1:0] vsrc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vreq_q <= 1'b0;
      vsrc_q <= '0;
    end else begin
      vreq_q <= take;
      if (take) vsrc_q <= src;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[CTL_GIE] = gie_q;
    ctrl_o[CTL_GRP] = grp_q;
    ctrl_o[CTL_MASK0 +: N_CORE] = core_mask_q;
    ctrl_o[CTL_FLAG0 +: N_CORE] = core_flag;
  end

  assign pflag_o    = per_flag;
  assign pmask_o    = per_mask_q;
  assign vec_req_o  = vreq_q;
  assign vec_addr_o = VEC_ADDR;
  assign vec_src_o  = vsrc_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_PERIPH-1:0] periph_req_i,
  input logic                iret_i,
  input logic                reg_wr_i,
  input logic [DATA_W-1:0]   ctrl_o,
  input logic [N_PERIPH-1:0] pflag_o,
  input logic                vec_req_o,
  input logic [ADDR_W-1:0]   vec_addr_o
);
  // R3
  take_clears_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> !ctrl_o[0]);

  // R3
  take_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |=> !vec_req_o);

  // R3
  take_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> (vec_addr_o == 13'h0004));

  // R2
  take_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> $past(ctrl_o[0]));

  // R4
  iret_sets_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && !ctrl_o[0]) |=> ctrl_o[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|periph_req_i) |=> ((pflag_o & $past(periph_req_i)) == $past(periph_req_i)));

  // R8
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> (($past(pflag_o) & ~pflag_o) == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_irq_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .periph_req_i(periph_req_i), .iret_i(iret_i),
  .reg_wr_i(reg_wr_i), .ctrl_o(ctrl_o), .pflag_o(pflag_o),
  .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf = 1'b0, ext_pin = 1'b0, rise_sel = 1'b1;
  logic [3:0] port_hi = '0;
  logic       port_acc = 1'b0, iret = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] wdata = '0, preq = '0;
  logic [7:0] ctrl, pflag, pmask;
  logic       vreq;
  logic [12:0] vaddr;
  logic [3:0] vsrc;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tmr_ovf_i(tmr_ovf), .ext_pin_i(ext_pin),
    .ext_rise_sel_i(rise_sel), .port_hi_i(port_hi), .port_access_i(port_acc),
    .periph_req_i(preq), .iret_i(iret), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(wdata), .ctrl_o(ctrl), .pflag_o(pflag), .pmask_o(pmask),
    .vec_req_o(vreq), .vec_addr_o(vaddr), .vec_src_o(vsrc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    reg_wr = 1'b0; reg_sel = 2'd3; preq = '0; tmr_ovf = 1'b0;
    iret = 1'b0; port_acc = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; wdata = d;
    tick();
    clr_strobes();
  endtask

  // {sel, wdata, periph_req, expected pflag}; global enable stays off
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {2'd2, 8'h00, 8'h05, 8'h05},  // R1 masks off, flags still latch
    {2'd3, 8'h00, 8'h80, 8'h85},  // R1
    {2'd1, 8'hFE, 8'h00, 8'h84},  // R8 zero bit clears
    {2'd1, 8'h00, 8'h04, 8'h04},  // R9 set beats clear
    {2'd3, 8'h00, 8'h00, 8'h04},  // R8 holds without write
    {2'd1, 8'hFB, 8'h10, 8'h10},  // R8/R9 mixed
    {2'd1, 8'h00, 8'h00, 8'h00}   // R8
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    // R4 reset state
    chk(ctrl == 8'h00, "R4 reset ctrl", ctrl, 0);
    chk(pflag == 8'h00 && pmask == 8'h00, "R4 reset pflag/pmask", {pflag, pmask}, 0);
    chk(vreq == 1'b0, "R4 reset vreq", vreq, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      reg_wr = (VEC[i][25:24] != 2'd3); reg_sel = VEC[i][25:24];
      wdata = VEC[i][23:16]; preq = VEC[i][15:8];
      tick();
      clr_strobes();
      chk(pflag == VEC[i][7:0], $sformatf("R1/R8/R9 vector %0d", i), pflag, VEC[i][7:0]);
    end

    // R2 group enable gate
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h01);
    preq = 8'h02; tick(); clr_strobes();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(vreq == 1'b0, "R2 group enable off", vreq, 0);
    end
    wr(2'd0, 8'h03);
    chk(ctrl == 8'h03, "R2 ctrl written", ctrl, 3);
    tick();
    chk(vreq == 1'b1, "R3 vector request", vreq, 1);
    chk(vaddr == 13'h0004, "R3 vector address", vaddr, 4);
    chk(vsrc == 4'd4, "R10 periph line 1 code", vsrc, 4);
    chk(ctrl[0] == 1'b0, "R3 gie cleared", ctrl[0], 0);
    chk(pflag[1] == 1'b1, "R8 take keeps flag", pflag[1], 1);
    tick();
    chk(vreq == 1'b0, "R3 single pulse", vreq, 0);

    // R4 return strobe
    iret = 1'b1; tick(); clr_strobes();
    chk(ctrl[0] == 1'b1, "R4 iret sets gie", ctrl[0], 1);
    tick();
    chk(vreq == 1'b1, "R2 flag still pending retaken", vreq, 1);
    wr(2'd1, 8'h00);
    chk(pflag == 8'h00, "R8 periph clear", pflag, 0);

    // R2 core mask gate with gie on
    wr(2'd0, 8'h03);
    tmr_ovf = 1'b1; tick(); clr_strobes();
    chk(ctrl[5] == 1'b1, "R1 timer flag latched masked", ctrl[5], 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(vreq == 1'b0, "R2 timer mask off", vreq, 0);
    end

    // R10 priority timer over periph
    wr(2'd0, 8'h3E);
    wr(2'd2, 8'h01);
    preq = 8'h01; tick(); clr_strobes();
    wr(2'd0, 8'h3F);
    tick();
    chk(vreq == 1'b1 && vsrc == 4'd1, "R10 timer wins", {vreq, vsrc}, 5'h11);
    wr(2'd0, 8'h1F);
    tick();
    chk(vreq == 1'b1 && vsrc == 4'd3, "R10 periph 0 next", {vreq, vsrc}, 5'h13);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // R11 / R7 external edge
    rise_sel = 1'b1; ext_pin = 1'b1;
    tick(); tick();
    chk(ctrl[6] == 1'b0, "R11 not before third edge", ctrl[6], 0);
    tick();
    chk(ctrl[6] == 1'b1, "R11 rising edge at third edge", ctrl[6], 1);
    wr(2'd0, 8'h00);
    ext_pin = 1'b0;
    repeat (5) tick();
    chk(ctrl[6] == 1'b0, "R7 falling ignored in rise mode", ctrl[6], 0);
    rise_sel = 1'b0; ext_pin = 1'b1;
    repeat (5) tick();
    chk(ctrl[6] == 1'b0, "R7 rising ignored in fall mode", ctrl[6], 0);
    ext_pin = 1'b0;
    repeat (5) tick();
    chk(ctrl[6] == 1'b1, "R7 falling edge sets", ctrl[6], 1);
    wr(2'd0, 8'h00);

    // R5 / R6 port change
    port_hi = 4'b0100;
    repeat (4) tick();
    chk(ctrl[7] == 1'b1, "R5 mismatch sets", ctrl[7], 1);
    wr(2'd0, 8'h00);
    chk(ctrl[7] == 1'b1, "R5 clear lost during mismatch", ctrl[7], 1);
    port_acc = 1'b1; tick(); clr_strobes();
    wr(2'd0, 8'h00);
    chk(ctrl[7] == 1'b0, "R6 clear holds after relatch", ctrl[7], 0);
    repeat (3) tick();
    chk(ctrl[7] == 1'b0, "R6 stays clear", ctrl[7], 0);

    // R8 software cannot set flags
    wr(2'd0, 8'hE0);
    chk(ctrl[7:5] == 3'b000, "R8 no software set", ctrl[7:5], 0);

    // R4 reset clears gie
    wr(2'd0, 8'h01);
    rst_n = 1'b0; tick();
    chk(ctrl == 8'h00, "R4 reset clears gie", ctrl, 0);
    rst_n = 1'b1; tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule